// File: doc/BRIEF.md
# Flash Access Protection Controller

This block guards an on-chip flash array against accidental modification and against access by code that should not see it. A requester issues one request at a time: a code-path read, a byte program, a page erase, or a data-space read. Each request is tagged with its origin: trusted code, untrusted code, or a debug port. The block checks the request against three things: a two-bit control register that enables programming and erasing, a cached security byte that sets how many pages are locked, and the reserved area at the top of the address space. It then either performs the operation on the array model or rejects it with an error.

The security byte sits in the last user byte of flash. Its bitwise inverse gives the number of locked pages, counted upward from page 0. The page that holds the security byte is locked whenever the byte is anything other than 0xFF. The cache is loaded from flash after every reset. It also follows any granted program to that address and any granted erase of its page, and the change applies to the very next request.

The request channel is valid/ready. The requester raises `req_valid` and holds the operation, source, address and data stable until it sees `req_ready` high at a clock edge. `req_ready` is low from acceptance until the response has been delivered, and it is also low during reset and the security-byte load that follows it. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse, and the requester must capture `rsp_err` and `rsp_rdata` in that cycle.

Top module: `flash_guard`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response has been delivered. Every accepted request gets exactly one single-cycle `rsp_valid` pulse. That pulse comes 2 cycles after acceptance, except for a granted page erase, where it comes 2 + 512 cycles after acceptance.
- R2: Operation encoding on `req_op`: 0 = code read, 1 = program byte, 2 = erase page, 3 = data-space read. A data-space read never reaches flash and is always rejected.
- R3: A program is granted only while the write-enable bit is 1. An erase is granted only while both the write-enable bit and the erase-enable bit are 1.
- R4: Pages are 512 bytes, so a page is address bits [11:9]. With security byte L, pages 0 to (~L)-1 are locked, where ~L is the 8-bit inverse of L.
- R5: The page holding the security byte (0xC00–0xDFF, byte at 0xDFF) is unlocked when L is 0xFF and locked when L is any other value.
- R6: Source encoding on `req_src`: 0 = trusted, 1 = untrusted, 2 = debug port, 3 = treated as untrusted. Any non-trusted request to a locked page is rejected. Trusted requests ignore the lock.
- R7: Addresses 0xE00 and above are reserved, and every request to them is rejected whatever the source.
- R8: A rejected request gives `rsp_err` = 1 for the one `rsp_valid` cycle, with `rsp_rdata` = 0x00, and leaves the array unchanged.
- R9: L is loaded from flash after reset, with `req_ready` held low until it has been loaded. Flash contents survive reset. A granted program of 0xDFF takes effect from the next request. A granted erase of the security page sets L to 0xFF.
- R10: The control register resets to 0. A `ctrl_wr` pulse loads `ctrl_wr_en` as the write-enable bit and `ctrl_er_en` as the erase-enable bit.
- R11: A granted erase fills its whole page with 0xFF. A granted code read returns the stored byte. Erased flash reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation code (R2) |
| req_src | input | 2 | Origin tag (R6) |
| req_addr | input | ADDR_W (12) | Byte address |
| req_wdata | input | 8 | Program data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 8 | Read data, 0x00 on reject |
| ctrl_wr | input | 1 | Load control register |
| ctrl_wr_en | input | 1 | Write-enable value to load |
| ctrl_er_en | input | 1 | Erase-enable value to load |

## Verification
On every cycle the assertions check the handshake and the response pulse. They also check that an error response carries zero data, that any array program seen in the check state is backed by the write-enable bit and never aimed at the reserved area, and that every erase starts with both enable bits set. Which pages a given security byte locks, how the lock interacts with each source, whether the lock survives reset, and whether erase and program leave the right contents can only be shown by the bench scenarios. Those scenarios read the data back through the request port.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    OP_CODE_RD = 2'd0,
    OP_PROG    = 2'd1,
    OP_ERASE   = 2'd2,
    OP_DATA_RD = 2'd3
  } fg_op_e;

  typedef enum logic [1:0] {
    SRC_TRUSTED   = 2'd0,
    SRC_UNTRUSTED = 2'd1,
    SRC_DEBUG     = 2'd2,
    SRC_OTHER     = 2'd3
  } fg_src_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_CHECK,
    ST_ERASE,
    ST_RESP
  } fg_state_e;
endpackage

// File: rtl/fg_lock_decode.sv
module fg_lock_decode #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_W     = 9,
  parameter int USER_BYTES = 3584
) (
  input  logic [7:0]        lock_byte,
  input  logic [ADDR_W-1:0] addr,
  output logic              page_locked,
  output logic              reserved
);
  localparam int PG_W      = ADDR_W - PAGE_W;
  localparam int LOCK_ADDR = USER_BYTES - 1;
  localparam int LOCK_PAGE = LOCK_ADDR >> PAGE_W;

  logic [PG_W-1:0] page;
  logic [7:0]      n_locked;
  logic            below_n;
  logic            any_lock;

  always_comb begin
    page     = addr[ADDR_W-1:PAGE_W];
    n_locked = ~lock_byte;
    below_n  = {{(32-PG_W){1'b0}}, page} < {24'b0, n_locked};
    any_lock = (lock_byte != 8'hFF);
    reserved = {{(32-ADDR_W){1'b0}}, addr} >= 32'(USER_BYTES);
    page_locked = any_lock && (below_n || (page == PG_W'(LOCK_PAGE)));
  end
endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import fg_pkg::*;
(
  input  fg_op_e  op,
  input  fg_src_e src,
  input  logic    page_locked,
  input  logic    reserved,
  input  logic    wr_en,
  input  logic    er_en,
  output logic    grant
);
  logic untrusted;
  logic op_ok;

  always_comb begin
    untrusted = (src != SRC_TRUSTED);
    unique case (op)
      OP_CODE_RD: op_ok = 1'b1;
      OP_PROG:    op_ok = wr_en;
      OP_ERASE:   op_ok = wr_en && er_en;
      default:    op_ok = 1'b0;
    endcase
    grant = op_ok && !reserved && !(page_locked && untrusted);
  end
endmodule

// File: rtl/fg_array.sv
module fg_array #(
  parameter int ADDR_W     = 12,
  parameter int USER_BYTES = 3584
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] cells [0:USER_BYTES-1];

  initial begin
    for (int i = 0; i < USER_BYTES; i++) cells[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we && ({{(32-ADDR_W){1'b0}}, waddr} < 32'(USER_BYTES)))
      cells[waddr] <= wdata;
  end

  always_comb begin
    if ({{(32-ADDR_W){1'b0}}, raddr} < 32'(USER_BYTES)) rdata = cells[raddr];
    else rdata = 8'h00;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_W     = 9,
  parameter int USER_BYTES = 3584
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [7:0]        rsp_rdata,
  input  logic              ctrl_wr,
  input  logic              ctrl_wr_en,
  input  logic              ctrl_er_en
);
  localparam int PG_W      = ADDR_W - PAGE_W;
  localparam int LOCK_ADDR = USER_BYTES - 1;
  localparam int LOCK_PAGE = LOCK_ADDR >> PAGE_W;

  fg_state_e         state;
  fg_op_e            op_q;
  fg_src_e           src_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [7:0]        lock_q;
  logic              wen_q, een_q;
  logic [PAGE_W-1:0] cnt_q;
  logic              err_q;
  logic [7:0]        rdata_q;

  logic              dec_locked, dec_reserved, grant;
  logic              arr_we, in_erase, erase_start, hits_lock_addr;
  logic [ADDR_W-1:0] arr_waddr, arr_raddr;
  logic [7:0]        arr_wdata, arr_rdata;

  fg_lock_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .USER_BYTES(USER_BYTES)) u_dec (
    .lock_byte(lock_q), .addr(addr_q), .page_locked(dec_locked), .reserved(dec_reserved)
  );

  fg_policy u_pol (
    .op(op_q), .src(src_q), .page_locked(dec_locked), .reserved(dec_reserved),
    .wr_en(wen_q), .er_en(een_q), .grant(grant)
  );

  fg_array #(.ADDR_W(ADDR_W), .USER_BYTES(USER_BYTES)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  always_comb begin
    in_erase       = (state == ST_ERASE);
    hits_lock_addr = (addr_q == ADDR_W'(LOCK_ADDR));
    erase_start    = (state == ST_CHECK) && grant && (op_q == OP_ERASE);
    arr_raddr      = (state == ST_BOOT) ? ADDR_W'(LOCK_ADDR) : addr_q;
    arr_we         = 1'b0;
    arr_waddr      = addr_q;
    arr_wdata      = wdata_q;
    if ((state == ST_CHECK) && grant && (op_q == OP_PROG)) arr_we = 1'b1;
    if (in_erase) begin
      arr_we    = 1'b1;
      arr_waddr = {addr_q[ADDR_W-1:PAGE_W], cnt_q};
      arr_wdata = 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_BOOT;
      op_q    <= OP_CODE_RD;
      src_q   <= SRC_TRUSTED;
      addr_q  <= '0;
      wdata_q <= '0;
      lock_q  <= 8'hFF;
      wen_q   <= 1'b0;
      een_q   <= 1'b0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr) begin
        wen_q <= ctrl_wr_en;
        een_q <= ctrl_er_en;
      end
      unique case (state)
        ST_BOOT: begin
          lock_q <= arr_rdata;
          state  <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= fg_op_e'(req_op);
            src_q   <= fg_src_e'(req_src);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          err_q   <= !grant;
          rdata_q <= 8'h00;
          state   <= ST_RESP;
          if (grant) begin
            unique case (op_q)
              OP_CODE_RD: rdata_q <= arr_rdata;
              OP_PROG:    if (hits_lock_addr) lock_q <= wdata_q;
              OP_ERASE: begin
                cnt_q <= '0;
                state <= ST_ERASE;
              end
              default: ;
            endcase
          end
        end
        ST_ERASE: begin
          cnt_q <= cnt_q + 1'b1;
          if (&cnt_q) begin
            state <= ST_RESP;
            if (addr_q[ADDR_W-1:PAGE_W] == PG_W'(LOCK_PAGE)) lock_q <= 8'hFF;
          end
        end
        ST_RESP: begin
          state <= ST_IDLE;
          err_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    rsp_valid = (state == ST_RESP);
    rsp_err   = (state == ST_RESP) && err_q;
    rsp_rdata = rdata_q;
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [7:0] rsp_rdata,
  input logic       arr_we,
  input logic       in_erase,
  input logic       erase_start,
  input logic       dec_reserved,
  input logic       wen_q,
  input logic       een_q
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R1
  AST_RSP_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R1
  AST_RSP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R1
  AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid); // R8
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == 8'h00); // R8
  AST_PROG_NEEDS_WE: assert property (@(posedge clk) disable iff (rst)
    arr_we && !in_erase |-> wen_q); // R3
  AST_ERASE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> wen_q && een_q); // R3
  AST_NO_RESERVED_PROG: assert property (@(posedge clk) disable iff (rst)
    arr_we && !in_erase |-> !dec_reserved); // R7
endmodule

bind flash_guard fg_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .arr_we(arr_we), .in_erase(in_erase), .erase_start(erase_start),
  .dec_reserved(dec_reserved), .wen_q(wen_q), .een_q(een_q)
);

// File: tb/flash_guard_test.sv
`timescale 1ns/1ps
module flash_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_src = 2'd0;
  logic [11:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [7:0]  rsp_rdata;
  logic        ctrl_wr = 1'b0, ctrl_wr_en = 1'b0, ctrl_er_en = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic       r_err;
  logic [7:0] r_data;

  localparam logic [1:0] RD = 2'd0, PR = 2'd1, ER = 2'd2, DR = 2'd3;
  localparam logic [1:0] TR = 2'd0, UN = 2'd1, DBG = 2'd2;

  always #2.5 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ctrl_wr(ctrl_wr), .ctrl_wr_en(ctrl_wr_en), .ctrl_er_en(ctrl_er_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [1:0] src,
                        input logic [11:0] addr, input logic [7:0] wd);
    int lat, guard, exp_lat;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_src = src; req_addr = addr; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1", "ready low after accept", int'(req_ready), 0);
    lat = 0;
    while (!rsp_valid && lat < 2000) begin @(negedge clk); lat++; end
    r_err = rsp_err;
    r_data = rsp_rdata;
    exp_lat = (op == ER && !r_err) ? 513 : 1;
    check(lat == exp_lat, "R1", "response latency", lat, exp_lat);
    @(negedge clk);
    check(!rsp_valid, "R1", "single response pulse", int'(rsp_valid), 0);
  endtask

  task automatic expect_rsp(input string req, input string what,
                            input logic e_err, input logic [7:0] e_data);
    check(r_err == e_err, req, {what, " err"}, int'(r_err), int'(e_err));
    check(r_data == e_data, req, {what, " data"}, int'(r_data), int'(e_data));
  endtask

  task automatic set_ctrl(input logic we, input logic ee);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wr_en = we; ctrl_er_en = ee;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!req_ready, "R9", "ready low in reset", int'(req_ready), 0);
    check(!rsp_valid, "R1", "no response in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    check(!req_ready, "R9", "ready low before lock load", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready, "R9", "ready after lock load", int'(req_ready), 1);
  endtask

  task automatic t_reset_state();
    apply_reset();
    do_req(PR, TR, 12'h100, 8'h11);
    expect_rsp("R10", "program with enables reset", 1'b1, 8'h00);
    do_req(RD, TR, 12'h100, 8'h00);
    expect_rsp("R8", "rejected program left cell", 1'b0, 8'hFF);
  endtask

  task automatic t_enables();
    set_ctrl(1'b1, 1'b0);
    do_req(PR, UN, 12'h100, 8'h5A);
    expect_rsp("R3", "program with write enable", 1'b0, 8'h00);
    do_req(RD, UN, 12'h100, 8'h00);
    expect_rsp("R11", "read back program", 1'b0, 8'h5A);
    do_req(ER, UN, 12'h000, 8'h00);
    expect_rsp("R3", "erase without erase enable", 1'b1, 8'h00);
    do_req(RD, UN, 12'h100, 8'h00);
    expect_rsp("R8", "rejected erase left data", 1'b0, 8'h5A);
    set_ctrl(1'b0, 1'b1);
    do_req(ER, TR, 12'h000, 8'h00);
    expect_rsp("R3", "erase without write enable", 1'b1, 8'h00);
    set_ctrl(1'b1, 1'b1);
    do_req(ER, UN, 12'h000, 8'h00);
    expect_rsp("R3", "erase with both enables", 1'b0, 8'h00);
    do_req(RD, UN, 12'h100, 8'h00);
    expect_rsp("R11", "erased mid-page", 1'b0, 8'hFF);
  endtask

  task automatic t_data_space();
    do_req(PR, TR, 12'h080, 8'h33);
    expect_rsp("R2", "program before data read", 1'b0, 8'h00);
    do_req(DR, TR, 12'h080, 8'h00);
    expect_rsp("R2", "data-space read", 1'b1, 8'h00);
    do_req(RD, TR, 12'h080, 8'h00);
    expect_rsp("R2", "code read same byte", 1'b0, 8'h33);
  endtask

  task automatic t_reserved();
    do_req(RD, TR, 12'hE00, 8'h00);
    expect_rsp("R7", "trusted read reserved", 1'b1, 8'h00);
    do_req(PR, TR, 12'hFFF, 8'h12);
    expect_rsp("R7", "trusted program reserved", 1'b1, 8'h00);
    do_req(ER, UN, 12'hE00, 8'h00);
    expect_rsp("R7", "erase reserved", 1'b1, 8'h00);
  endtask

  task automatic t_lock_fd();
    do_req(PR, TR, 12'h300, 8'h77);
    do_req(PR, TR, 12'h400, 8'h44);
    do_req(PR, UN, 12'hC00, 8'h22);
    expect_rsp("R5", "untrusted program of open lock page", 1'b0, 8'h00);
    do_req(PR, TR, 12'hDFF, 8'hFD);
    expect_rsp("R9", "program lock byte", 1'b0, 8'h00);
    do_req(RD, UN, 12'h3FF, 8'h00);
    expect_rsp("R4", "last byte of page 1 locked", 1'b1, 8'h00);
    do_req(RD, UN, 12'h400, 8'h00);
    expect_rsp("R4", "page 2 open", 1'b0, 8'h44);
    do_req(RD, DBG, 12'h000, 8'h00);
    expect_rsp("R6", "debug read page 0", 1'b1, 8'h00);
    do_req(RD, UN, 12'hC00, 8'h00);
    expect_rsp("R5", "lock page now locked", 1'b1, 8'h00);
    do_req(RD, DBG, 12'hBFF, 8'h00);
    expect_rsp("R4", "page 5 open to debug", 1'b0, 8'hFF);
    do_req(RD, TR, 12'h300, 8'h00);
    expect_rsp("R6", "trusted read locked page", 1'b0, 8'h77);
    do_req(PR, UN, 12'h300, 8'h99);
    expect_rsp("R6", "untrusted program locked", 1'b1, 8'h00);
    do_req(RD, TR, 12'h300, 8'h00);
    expect_rsp("R8", "locked cell unchanged", 1'b0, 8'h77);
  endtask

  task automatic t_reset_persist();
    apply_reset();
    do_req(RD, UN, 12'h300, 8'h00);
    expect_rsp("R9", "lock survives reset", 1'b1, 8'h00);
    do_req(PR, TR, 12'h300, 8'h01);
    expect_rsp("R10", "enables cleared by reset", 1'b1, 8'h00);
    set_ctrl(1'b1, 1'b1);
  endtask

  task automatic t_lock_fe_00();
    do_req(PR, TR, 12'hDFF, 8'hFE);
    do_req(RD, UN, 12'h000, 8'h00);
    expect_rsp("R4", "0xFE locks page 0", 1'b1, 8'h00);
    do_req(RD, UN, 12'h300, 8'h00);
    expect_rsp("R4", "0xFE leaves page 1 open", 1'b0, 8'h77);
    do_req(RD, DBG, 12'hC00, 8'h00);
    expect_rsp("R5", "0xFE locks lock page", 1'b1, 8'h00);
    do_req(PR, TR, 12'hDFF, 8'h00);
    do_req(RD, UN, 12'hA00, 8'h00);
    expect_rsp("R4", "0x00 locks page 5", 1'b1, 8'h00);
  endtask

  task automatic t_unlock();
    do_req(ER, TR, 12'hC00, 8'h00);
    expect_rsp("R9", "trusted erase of lock page", 1'b0, 8'h00);
    do_req(RD, UN, 12'h000, 8'h00);
    expect_rsp("R9", "page 0 open after erase", 1'b0, 8'hFF);
    do_req(RD, UN, 12'hC00, 8'h00);
    expect_rsp("R11", "lock page erased", 1'b0, 8'hFF);
    do_req(RD, UN, 12'hDFF, 8'h00);
    expect_rsp("R5", "lock byte readable when 0xFF", 1'b0, 8'hFF);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_enables();
    t_data_space();
    t_reserved();
    t_lock_fd();
    t_reset_persist();
    t_lock_fe_00();
    t_unlock();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule